// File: doc/BRIEF.md
# Two-Port GPIO Core with Change-Detect Interrupt

This core holds the pin-facing state of a 16-pin general-purpose I/O expander built as two 8-bit ports. A per-pin direction register, output-data register and interrupt-mask register are written by the serial bus front end through a simple one-cycle write strobe. Port 0 drives its pins push-pull. Port 1 behaves as open drain: it either drives the pin low or releases it.

Inputs pass through a two-stage synchronizer. When the bus front end acknowledges the target address, the synchronized pin levels are captured into a snapshot and the active-low interrupt is released. The snapshot is what the bus reads back. Any later difference between an enabled input pin and the snapshot sets a sticky change flag, which pulls the interrupt low.

When a one-byte port read ends with STOP, the front end pulses a completion event. That event clears the flags, and detection restarts against the snapshot that was sent, so a pin that moved during the transfer raises the interrupt again at once.

Top module: `gpx_core`

## Requirements
- R1: After reset every pin is an input, every interrupt is masked, the output data is all ones, `irq_n` is 1 and `pin_oe` is all zero.
- R2: A write with `wr_en`=1 updates the byte selected by `wr_port` on the next clock edge. The register is chosen by `wr_kind`: 0 = direction (1 input, 0 output), 1 = output data, 2 = interrupt mask (1 disabled, 0 enabled). A `wr_kind` of 3 changes nothing.
- R3: On port 0 (pins 7:0), `pin_oe` is the inverse of the direction bit and `pin_out` equals the output-data bit.
- R4: On port 1 (pins 15:8), `pin_out` is always 0 and `pin_oe` is 1 only for an output pin whose data bit is 0.
- R5: `pins_in` passes through two register stages. A snapshot taken at a given edge therefore holds the pin levels from two edges earlier.
- R6: `rd_data` is the snapshot byte of the port selected by `rd_port`. It changes only when a snapshot is taken.
- R7: `irq_n` goes to 0 on the third clock edge after an enabled input pin starts to differ from the snapshot.
- R8: A pin that is set to output or is masked never causes `irq_n` to fall.
- R9: An `addr_ack` pulse loads the snapshot and clears all change flags, so `irq_n` is 1 after that edge.
- R10: Flags are sticky until `addr_ack` or `read_done`. After `read_done` clears them, a pin that still differs from the snapshot sets `irq_n` low again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register select: 0 direction, 1 output data, 2 mask, 3 none |
| wr_port | input | 1 | Port (byte) select for the write |
| wr_data | input | 8 | Write data |
| addr_ack | input | 1 | Target address acknowledged: take snapshot, release interrupt |
| read_done | input | 1 | One-byte port read ended with STOP: clear change flags |
| rd_port | input | 1 | Port select for read data |
| rd_data | output | 8 | Snapshot byte of the selected port |
| pins_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Pin drive value |
| pin_oe | output | 16 | Pin drive enable |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- an `addr_ack` or `read_done` always leaves `irq_n` high on the following edge;
- a falling `irq_n` always follows an enabled, unmasked input mismatch;
- the open-drain port never drives a 1;
- an unused `wr_kind` leaves the pins untouched;
- `rd_data` moves only with a snapshot.

Other behaviours need the bench's scenarios:
- the exact three-edge latency from a pin change to the interrupt;
- the stickiness of a flag after the pin returns to its snapshot value;
- the re-assertion straight after `read_done`;
- the two-edge-old value captured when a pin moves in the acknowledge cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_OUT  = 2'd1,
        REG_MASK = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic take;   // load snapshot and clear flags
        logic clear;  // clear flags only
    } evt_t;

    function automatic evt_t decode_evt(input logic ack, input logic done);
        evt_t e;
        e.take  = ack;
        e.clear = done & ~ack;
        return e;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    localparam int W        = PORT_W * NUM_PORTS,
    localparam int PIDX_W   = idx_width(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [PIDX_W-1:0] wr_port,
    input  logic [PORT_W-1:0] wr_data,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      mask_q
);
    reg_kind_e kind;
    assign kind = reg_kind_e'(wr_kind);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = wr_en && (wr_port == PIDX_W'(p));

            always_ff @(posedge clk) begin
                if (rst) begin
                    dir_q [p*PORT_W +: PORT_W] <= '1;
                    out_q [p*PORT_W +: PORT_W] <= '1;
                    mask_q[p*PORT_W +: PORT_W] <= '1;
                end else if (hit) begin
                    case (kind)
                        REG_DIR:  dir_q [p*PORT_W +: PORT_W] <= wr_data;
                        REG_OUT:  out_q [p*PORT_W +: PORT_W] <= wr_data;
                        REG_MASK: mask_q[p*PORT_W +: PORT_W] <= wr_data;
                        default:  ;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpx_detect.sv
module gpx_detect
    import gpx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  evt_t         evt,
    input  logic [W-1:0] sync_val,
    input  logic [W-1:0] dir_val,
    input  logic [W-1:0] mask_val,
    output logic [W-1:0] snap_q,
    output logic         irq_n
);
    logic [W-1:0] flags_q;
    logic [W-1:0] armed;

    // enabled input pins that no longer match the snapshot
    assign armed = (sync_val ^ snap_q) & dir_val & ~mask_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            flags_q <= '0;
        end else begin
            if (evt.take) snap_q <= sync_val;
            if (evt.take || evt.clear) flags_q <= '0;
            else                       flags_q <= flags_q | armed;
        end
    end

    assign irq_n = ~|flags_q;
endmodule

// File: rtl/gpx_drive.sv
module gpx_drive #(
    parameter int                   PORT_W    = 8,
    parameter int                   NUM_PORTS = 2,
    parameter logic [NUM_PORTS-1:0] OD_PORTS  = 2'b10,
    localparam int                  W         = PORT_W * NUM_PORTS
) (
    input  logic [W-1:0] dir_val,
    input  logic [W-1:0] out_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam int LO = p * PORT_W;
            if (OD_PORTS[p]) begin : g_od
                assign pin_out[LO +: PORT_W] = '0;
                assign pin_oe [LO +: PORT_W] = ~dir_val[LO +: PORT_W] & ~out_val[LO +: PORT_W];
            end else begin : g_pp
                assign pin_out[LO +: PORT_W] = out_val[LO +: PORT_W];
                assign pin_oe [LO +: PORT_W] = ~dir_val[LO +: PORT_W];
            end
        end
    endgenerate
endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int                   PORT_W      = 8,
    parameter int                   NUM_PORTS   = 2,
    parameter int                   SYNC_STAGES = 2,
    parameter logic [NUM_PORTS-1:0] OD_PORTS    = 2'b10,
    localparam int                  W           = PORT_W * NUM_PORTS,
    localparam int                  PIDX_W      = idx_width(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [PIDX_W-1:0] wr_port,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              addr_ack,
    input  logic              read_done,
    input  logic [PIDX_W-1:0] rd_port,
    output logic [PORT_W-1:0] rd_data,
    input  logic [W-1:0]      pins_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq_n
);
    logic [W-1:0] sync_val, dir_q, out_q, mask_q, snap_q;
    evt_t         evt;

    assign evt = decode_evt(addr_ack, read_done);

    gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(pins_in), .q(sync_val)
    );

    gpx_regs #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_port(wr_port), .wr_data(wr_data),
        .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q)
    );

    gpx_detect #(.W(W)) detect_i (
        .clk(clk), .rst(rst), .evt(evt), .sync_val(sync_val),
        .dir_val(dir_q), .mask_val(mask_q), .snap_q(snap_q), .irq_n(irq_n)
    );

    gpx_drive #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .OD_PORTS(OD_PORTS)) drive_i (
        .dir_val(dir_q), .out_val(out_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign rd_data = snap_q[rd_port*PORT_W +: PORT_W];
endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
    parameter int                   PORT_W    = 8,
    parameter int                   NUM_PORTS = 2,
    parameter int                   PIDX_W    = 1,
    parameter logic [NUM_PORTS-1:0] OD_PORTS  = 2'b10,
    localparam int                  W         = PORT_W * NUM_PORTS
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_kind,
    input logic              addr_ack,
    input logic              read_done,
    input logic [PIDX_W-1:0] rd_port,
    input logic [PORT_W-1:0] rd_data,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              irq_n,
    input logic [W-1:0]      sync_val,
    input logic [W-1:0]      snap_val,
    input logic [W-1:0]      dir_val,
    input logic [W-1:0]      mask_val
);
    // R1: interrupt released on the first cycle out of reset
    a_r1_reset_irq_released: assert property (@(posedge clk) $past(rst) |-> irq_n);

    // R2: an unused register select leaves the pins untouched
    a_r2_kind3_no_effect: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd3) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R6: read data moves only with a snapshot
    a_r6_rd_stable: assert property (@(posedge clk) disable iff (rst)
        (!$past(addr_ack) && $stable(rd_port)) |-> $stable(rd_data));

    // R8: a falling interrupt needs an enabled input mismatch
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(|((sync_val ^ snap_val) & dir_val & ~mask_val)));

    // R9: acknowledge releases the interrupt
    a_r9_ack_releases: assert property (@(posedge clk) disable iff (rst)
        addr_ack |=> irq_n);

    // R10: read completion releases the interrupt for one edge
    a_r10_done_releases: assert property (@(posedge clk) disable iff (rst)
        read_done |=> irq_n);

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_od
            if (OD_PORTS[p]) begin : g_chk
                // R4: open-drain port never drives a one
                a_r4_od_no_high: assert property (@(posedge clk) disable iff (rst)
                    pin_out[p*PORT_W +: PORT_W] == '0);
            end
        end
    endgenerate
endmodule

bind gpx_core gpx_core_chk #(
    .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W), .OD_PORTS(OD_PORTS)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
    .addr_ack(addr_ack), .read_done(read_done), .rd_port(rd_port),
    .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n),
    .sync_val(sync_val), .snap_val(snap_q), .dir_val(dir_q), .mask_val(mask_q)
);

// File: tb/gpx_core_tb.sv
module gpx_core_tb_top;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd0;
    logic        wr_port = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        addr_ack = 1'b0;
    logic        read_done = 1'b0;
    logic        rd_port = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] pins_in = 16'h0000;
    logic [15:0] pin_out, pin_oe;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    gpx_core dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_port(wr_port),
        .wr_data(wr_data), .addr_ack(addr_ack), .read_done(read_done),
        .rd_port(rd_port), .rd_data(rd_data), .pins_in(pins_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: two-deep input history, snapshot, sticky flags
    logic [15:0] hist [$];
    logic [15:0] m_snap, m_flags, m_dir, m_out, m_mask;

    always @(posedge clk) begin : model
        logic [15:0] oldest, nf;
        if (rst) begin
            hist = {16'h0000, 16'h0000};
            m_snap = 16'h0000; m_flags = 16'h0000;
            m_dir = 16'hFFFF; m_out = 16'hFFFF; m_mask = 16'hFFFF;
        end else begin
            oldest = hist[0];
            nf = m_flags | ((oldest ^ m_snap) & m_dir & ~m_mask);
            if (addr_ack) begin
                m_snap = oldest;
                nf = 16'h0000;
            end else if (read_done) begin
                nf = 16'h0000;
            end
            m_flags = nf;
            if (wr_en) begin
                case (wr_kind)
                    2'd0: if (wr_port) m_dir[15:8]  = wr_data; else m_dir[7:0]  = wr_data;
                    2'd1: if (wr_port) m_out[15:8]  = wr_data; else m_out[7:0]  = wr_data;
                    2'd2: if (wr_port) m_mask[15:8] = wr_data; else m_mask[7:0] = wr_data;
                    default: ;
                endcase
            end
            void'(hist.pop_front());
            hist.push_back(pins_in);
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3 pin_oe model", pin_oe, {~m_dir[15:8] & ~m_out[15:8], ~m_dir[7:0]});
            chk("R4 pin_out model", pin_out, {8'h00, m_out[7:0]});
            chk("R7 irq_n model", {15'd0, irq_n}, {15'd0, ~|m_flags});
            chk("R6 rd_data model", {8'h00, rd_data},
                {8'h00, rd_port ? m_snap[15:8] : m_snap[7:0]});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] k, input logic p, input logic [7:0] d);
        wr_en = 1'b1; wr_kind = k; wr_port = p; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        addr_ack = 1'b1;
        step(1);
        addr_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 pin_out", pin_out, 16'h00FF);

        // R2/R3/R4 register writes and drive modes
        wr(2'd0, 1'b0, 8'h00);
        wr(2'd1, 1'b0, 8'hA5);
        wr(2'd0, 1'b1, 8'h0F);
        wr(2'd1, 1'b1, 8'h3C);
        chk("R3 pin_oe port0", {8'h00, pin_oe[7:0]}, 16'h00FF);
        chk("R3 pin_out port0", {8'h00, pin_out[7:0]}, 16'h00A5);
        chk("R4 pin_oe port1", {8'h00, pin_oe[15:8]}, 16'h00C0);
        chk("R4 pin_out port1", {8'h00, pin_out[15:8]}, 16'h0000);

        wr(2'd3, 1'b1, 8'h00);
        chk("R2 kind3 pin_oe", pin_oe, 16'hC0FF);
        chk("R2 kind3 pin_out", pin_out, 16'h00A5);

        wr(2'd2, 1'b1, 8'hF0);
        wr(2'd2, 1'b0, 8'h00);
        ack();
        step(2);

        // R7 latency
        pins_in = 16'h0100;
        step(1); chk("R7 irq after 1 edge", {15'd0, irq_n}, 16'h0001);
        step(1); chk("R7 irq after 2 edges", {15'd0, irq_n}, 16'h0001);
        step(1); chk("R7 irq after 3 edges", {15'd0, irq_n}, 16'h0000);

        // R9 acknowledge
        ack();
        chk("R9 irq released", {15'd0, irq_n}, 16'h0001);
        rd_port = 1'b1;
        step(1);
        chk("R9 snapshot port1", {8'h00, rd_data}, 16'h0001);

        // R8 outputs and masked inputs
        pins_in = 16'h1101;
        step(5);
        chk("R8 output pins", {15'd0, irq_n}, 16'h0001);
        wr(2'd0, 1'b1, 8'hFF);
        step(4);
        chk("R8 masked input", {15'd0, irq_n}, 16'h0001);

        // R10 sticky flag
        pins_in = 16'h1301;
        step(3);
        chk("R10 irq set", {15'd0, irq_n}, 16'h0000);
        pins_in = 16'h1101;
        step(4);
        chk("R10 sticky after return", {15'd0, irq_n}, 16'h0000);

        ack();
        chk("R9 release again", {15'd0, irq_n}, 16'h0001);
        chk("R6 rd port1", {8'h00, rd_data}, 16'h0011);
        rd_port = 1'b0;
        step(1);
        chk("R6 rd port0", {8'h00, rd_data}, 16'h0001);

        // R10 read completion re-arms against the sent snapshot
        pins_in = 16'h1501;
        step(3);
        chk("R10 change before done", {15'd0, irq_n}, 16'h0000);
        read_done = 1'b1;
        step(1);
        read_done = 1'b0;
        chk("R10 released by done", {15'd0, irq_n}, 16'h0001);
        step(1);
        chk("R10 re-asserted", {15'd0, irq_n}, 16'h0000);

        // R5 snapshot uses synchronized (two-edge-old) value
        rd_port = 1'b1;
        pins_in = 16'h1D01;
        ack();
        chk("R5 old value captured", {8'h00, rd_data}, 16'h0015);
        step(2);
        chk("R5 later change flagged", {15'd0, irq_n}, 16'h0000);
        ack();
        chk("R5 new snapshot", {8'h00, rd_data}, 16'h001D);

        step(2);
        finish_run();
    end
endmodule